// File: doc/BRIEF.md
# Shared-Net Strength Resolver

This block decides the logic state of one net that several outputs drive at the same time. Each driver offers an enable, the level it wants to put on the net, and two 6-bit strengths: one that applies while it drives a 1 and one that applies while it drives a 0. A driver can therefore be strong at one level and high impedance at the other, as an open-drain output is. The block works out each driver's effective strength, finds the highest, and checks whether the strongest driver clears every other driver by a programmable overdrive margin.

A driver that clears the margin sets the net. Otherwise the net takes the level shared by all drivers within the margin of the strongest, or X if those drivers disagree. A net with no driver above strength 0 resolves to Z. The resolved state and the winning strength come out of an optional output register.

Top module: `net_resolver`

## Requirements
- R1: A driver with level 1 uses its high-level strength and a driver with level 0 uses its low-level strength; the other strength field of that driver has no effect.
- R2: A driver whose active bit is 0 counts as strength 0, whatever its level and strength fields hold.
- R3: When the strongest effective strength is at least `margin` greater than every other nonzero effective strength, the net takes that driver's level, encoded 2'b00 for 0 and 2'b01 for 1.
- R4: When every effective strength is 0, the net state is Z, encoded 2'b10, and the reported strength is 0.
- R5: A contender is a driver of nonzero strength whose strength equals the maximum or lies less than `margin` below it; when contenders drive both levels the net state is X, encoded 2'b11.
- R6: When all contenders drive the same level, the net takes that level even though no single driver clears the margin.
- R7: The margin is a 6-bit input applied on every cycle; with margin 0 only drivers tied at the maximum contend, and with margin 63 every nonzero driver contends against a forcing driver of strength 63.
- R8: `net_strength` equals the highest effective strength of all drivers.
- R9: With `REG_OUT` = 1 the outputs change one clock after the inputs, and during reset they read Z with strength 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| drv_active | input | N_DRV | Per-driver enable |
| drv_level | input | N_DRV | Per-driver level (1 or 0) |
| drv_str_hi | input | N_DRV*STR_W | Packed strengths used when driving 1, driver i at bits [i*STR_W +: STR_W] |
| drv_str_lo | input | N_DRV*STR_W | Packed strengths used when driving 0, same packing |
| margin | input | STR_W | Overdrive margin |
| net_state | output | 2 | Resolved state: 00 = 0, 01 = 1, 10 = Z, 11 = X |
| net_strength | output | STR_W | Highest effective strength |

## Verification
The bench builds the block with its defaults: eight drivers, 6-bit strengths and the output register enabled. Eight drivers let one case combine a weak pull-up, a strong pull-down, idle drivers holding strong values, and several contenders close to the maximum. The full 6-bit strength range brings the forcing value 63 and the margin limits 0 and 63 into reach. The registered output makes the one-cycle latency and the reset value observable.

// File: rtl/net_resolver_pkg.sv
// Package: shared types for the shared-net strength resolver.
// Assumes the state encoding below is fixed; neighbours decode it.
package net_resolver_pkg;

    typedef enum logic [1:0] {
        NET_LO = 2'b00,
        NET_HI = 2'b01,
        NET_Z  = 2'b10,
        NET_X  = 2'b11
    } net_state_e;

endpackage

// File: rtl/drv_strength_sel.sv
// Module: drv_strength_sel
// Picks the effective strength of one driver from its enable, its level
// and its two level-dependent strengths. Assumes nothing about ordering
// of the two strengths; an idle driver always yields 0.
module drv_strength_sel #(
    parameter int STR_W = 6
) (
    input  logic             active,
    input  logic             level,
    input  logic [STR_W-1:0] str_hi,
    input  logic [STR_W-1:0] str_lo,
    output logic [STR_W-1:0] eff_str
);

    // Select the strength matching the driven level, or zero when idle.
    always_comb begin
        if (!active)
            eff_str = '0;
        else if (level)
            eff_str = str_hi;
        else
            eff_str = str_lo;
    end

endmodule

// File: rtl/strength_max_tree.sv
// Module: strength_max_tree
// Finds the highest of N_IN unsigned strengths with a balanced pairwise
// tree. Assumes N_IN >= 1; unused tree leaves are padded with zero.
module strength_max_tree #(
    parameter int N_IN  = 8,
    parameter int STR_W = 6
) (
    input  logic [N_IN-1:0][STR_W-1:0] strs,
    output logic [STR_W-1:0]           max_str
);

    localparam int LEVELS = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int LEAVES = 1 << LEVELS;

    logic [LEVELS:0][LEAVES-1:0][STR_W-1:0] node;

    // Load the leaves, padding unused ones with strength zero.
    always_comb begin
        node[0] = '0;
        for (int i = 0; i < N_IN; i++)
            node[0][i] = strs[i];
    end

    genvar lv, k;
    generate
        for (lv = 0; lv < LEVELS; lv++) begin : g_level
            for (k = 0; k < (LEAVES >> (lv + 1)); k++) begin : g_pair
                // Keep the larger of each pair at this level.
                always_comb begin
                    node[lv+1][k] = (node[lv][2*k] >= node[lv][2*k+1])
                                  ? node[lv][2*k] : node[lv][2*k+1];
                end
            end
            for (k = (LEAVES >> (lv + 1)); k < LEAVES; k++) begin : g_pad
                // Unused upper slots of this level stay zero.
                always_comb node[lv+1][k] = '0;
            end
        end
    endgenerate

    assign max_str = node[LEVELS][0];

endmodule

// File: rtl/contender_vote.sv
// Module: contender_vote
// Marks every driver of nonzero strength that sits at the maximum or less
// than the margin below it, and reports which levels those contenders drive.
// Assumes every strength is at most max_str.
module contender_vote #(
    parameter int N_IN  = 8,
    parameter int STR_W = 6
) (
    input  logic [N_IN-1:0][STR_W-1:0] strs,
    input  logic [N_IN-1:0]            levels,
    input  logic [STR_W-1:0]           max_str,
    input  logic [STR_W-1:0]           margin,
    output logic                       any_hi,
    output logic                       any_lo
);

    logic [N_IN-1:0] contend;

    genvar i;
    generate
        for (i = 0; i < N_IN; i++) begin : g_drv
            logic [STR_W-1:0] gap;
            // Distance below the maximum and contender decision for one driver.
            always_comb begin
                gap        = max_str - strs[i];
                contend[i] = (strs[i] != '0) && ((gap == '0) || (gap < margin));
            end
        end
    endgenerate

    // Gather the levels driven by the contenders.
    always_comb begin
        any_hi = |(contend & levels);
        any_lo = |(contend & ~levels);
    end

endmodule

// File: rtl/net_resolver.sv
// Module: net_resolver (top)
// Resolves one shared net from N_DRV drivers with level-dependent strengths
// and a programmable overdrive margin. Output is registered when REG_OUT=1,
// combinational otherwise. Assumes drv_str_* pack driver i at [i*STR_W +: STR_W].
module net_resolver
    import net_resolver_pkg::*;
#(
    parameter int N_DRV   = 8,
    parameter int STR_W   = 6,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_DRV-1:0]       drv_active,
    input  logic [N_DRV-1:0]       drv_level,
    input  logic [N_DRV*STR_W-1:0] drv_str_hi,
    input  logic [N_DRV*STR_W-1:0] drv_str_lo,
    input  logic [STR_W-1:0]       margin,
    output logic [1:0]             net_state,
    output logic [STR_W-1:0]       net_strength
);

    logic [N_DRV-1:0][STR_W-1:0] eff;
    logic [STR_W-1:0]            max_str;
    logic                        any_hi;
    logic                        any_lo;
    net_state_e                  state_c;

    genvar d;
    generate
        for (d = 0; d < N_DRV; d++) begin : g_sel
            drv_strength_sel #(.STR_W(STR_W)) u_sel (
                .active  (drv_active[d]),
                .level   (drv_level[d]),
                .str_hi  (drv_str_hi[d*STR_W +: STR_W]),
                .str_lo  (drv_str_lo[d*STR_W +: STR_W]),
                .eff_str (eff[d])
            );
        end
    endgenerate

    strength_max_tree #(.N_IN(N_DRV), .STR_W(STR_W)) u_max (
        .strs    (eff),
        .max_str (max_str)
    );

    contender_vote #(.N_IN(N_DRV), .STR_W(STR_W)) u_vote (
        .strs    (eff),
        .levels  (drv_level),
        .max_str (max_str),
        .margin  (margin),
        .any_hi  (any_hi),
        .any_lo  (any_lo)
    );

    // Turn the contender vote into the four-valued net state.
    always_comb begin
        if (max_str == '0)
            state_c = NET_Z;
        else if (any_hi && any_lo)
            state_c = NET_X;
        else if (any_hi)
            state_c = NET_HI;
        else
            state_c = NET_LO;
    end

    generate
        if (REG_OUT) begin : g_reg
            // Register the resolved state and strength; reset to Z, strength 0.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    net_state    <= NET_Z;
                    net_strength <= '0;
                end else begin
                    net_state    <= state_c;
                    net_strength <= max_str;
                end
            end
        end else begin : g_comb
            // Pass the resolved values straight through.
            always_comb begin
                net_state    = state_c;
                net_strength = max_str;
            end
        end
    endgenerate

endmodule

// File: rtl/net_resolver_checker.sv
// Module: net_resolver_checker
// Properties on the resolver's ports. Inputs are delayed to line up with
// the output register when REG_OUT=1. Bound to every net_resolver instance.
module net_resolver_checker #(
    parameter int N_DRV   = 8,
    parameter int STR_W   = 6,
    parameter bit REG_OUT = 1'b1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_DRV-1:0]       drv_active,
    input logic [N_DRV-1:0]       drv_level,
    input logic [1:0]             net_state,
    input logic [STR_W-1:0]       net_strength
);

    logic [N_DRV-1:0] d_active;
    logic [N_DRV-1:0] d_level;

    generate
        if (REG_OUT) begin : g_dly
            // Delay the inputs by the output register's latency.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d_active <= '0;
                    d_level  <= '0;
                end else begin
                    d_active <= drv_active;
                    d_level  <= drv_level;
                end
            end
        end else begin : g_nodly
            // No latency: observe inputs directly.
            always_comb begin
                d_active = drv_active;
                d_level  = drv_level;
            end
        end
    endgenerate

    // R2 / R4: no active driver leaves the net at Z with zero strength.
    a_r2_idle_is_z: assert property (@(posedge clk) disable iff (!rst_n)
        (d_active == '0) |-> (net_state == 2'b10 && net_strength == '0));

    // R4 / R8: the Z state and zero strength always appear together.
    a_r4_z_iff_zero_strength: assert property (@(posedge clk) disable iff (!rst_n)
        (net_state == 2'b10) == (net_strength == '0));

    // R5: a lone active driver can never produce X.
    a_r5_single_no_x: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(d_active) |-> (net_state != 2'b11));

    // R1 / R3: a lone driver above Z strength puts its own level on the net.
    a_r1_single_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot(d_active) && net_state != 2'b10)
            |-> (net_state == {1'b0, |(d_level & d_active)}));

endmodule

bind net_resolver net_resolver_checker #(
    .N_DRV   (N_DRV),
    .STR_W   (STR_W),
    .REG_OUT (REG_OUT)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .drv_active   (drv_active),
    .drv_level    (drv_level),
    .net_state    (net_state),
    .net_strength (net_strength)
);

// File: tb/net_resolver_bench.sv
// Bench: behavioural reference model of the resolution rule, compared at
// every falling edge against the registered outputs of the previous cycle.
module net_resolver_bench;

    localparam int N  = 8;
    localparam int SW = 6;
    localparam int WATCHDOG_CYCLES = 200000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      drv_active = '0;
    logic [N-1:0]      drv_level = '0;
    logic [N*SW-1:0]   drv_str_hi = '0;
    logic [N*SW-1:0]   drv_str_lo = '0;
    logic [SW-1:0]     margin = 6'd3;
    logic [1:0]        net_state;
    logic [SW-1:0]     net_strength;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int act [N];
    int lvl [N];
    int shi [N];
    int slo [N];
    int mrg;

    bit    pend = 0;
    int    exp_state;
    int    exp_str;
    string exp_tag;

    always #10 clk = ~clk;

    net_resolver u_net_resolver (
        .clk          (clk),
        .rst_n        (rst_n),
        .drv_active   (drv_active),
        .drv_level    (drv_level),
        .drv_str_hi   (drv_str_hi),
        .drv_str_lo   (drv_str_lo),
        .margin       (margin),
        .net_state    (net_state),
        .net_strength (net_strength)
    );

    task automatic check(string tag, int got, int want, string what);
        checks++;
        if (got != want) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, want);
        end
    endtask

    task automatic clear_drivers();
        for (int i = 0; i < N; i++) begin
            act[i] = 0; lvl[i] = 0; shi[i] = 0; slo[i] = 0;
        end
        mrg = 3;
    endtask

    task automatic set_drv(int i, int a, int l, int h, int lo);
        act[i] = a; lvl[i] = l; shi[i] = h; slo[i] = lo;
    endtask

    // Reference: effective strengths, maximum, contender levels.
    task automatic model(output int st, output int s);
        int e [N];
        bit hi_seen, lo_seen;
        s = 0; hi_seen = 0; lo_seen = 0;
        for (int i = 0; i < N; i++) begin
            e[i] = (act[i] == 0) ? 0 : (lvl[i] != 0 ? shi[i] : slo[i]);
            if (e[i] > s) s = e[i];
        end
        for (int i = 0; i < N; i++) begin
            if (e[i] > 0 && (e[i] == s || s - e[i] < mrg)) begin
                if (lvl[i] != 0) hi_seen = 1; else lo_seen = 1;
            end
        end
        if (s == 0)                st = 2;
        else if (hi_seen && lo_seen) st = 3;
        else if (hi_seen)          st = 1;
        else                       st = 0;
    endtask

    task automatic compare_pending();
        if (pend) begin
            check(exp_tag, int'(net_state), exp_state, "net_state");
            check("R8", int'(net_strength), exp_str, "net_strength");
        end
    endtask

    // One cycle: check last vector's result, then drive and predict the next.
    task automatic step(string tag);
        @(negedge clk);
        compare_pending();
        for (int i = 0; i < N; i++) begin
            drv_active[i] = act[i][0];
            drv_level[i]  = lvl[i][0];
            drv_str_hi[i*SW +: SW] = shi[i][SW-1:0];
            drv_str_lo[i*SW +: SW] = slo[i][SW-1:0];
        end
        margin = mrg[SW-1:0];
        model(exp_state, exp_str);
        exp_tag = tag;
        pend = 1;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int st, s;
        clear_drivers();
        // R9: reset state, with drivers already presenting a strong value.
        drv_active = '1; drv_level = '1; drv_str_hi = '1;
        repeat (3) @(negedge clk);
        check("R9", int'(net_state), 2, "reset net_state");
        check("R9", int'(net_strength), 0, "reset net_strength");
        drv_active = '0;
        rst_n = 1'b1;

        // R2: idle drivers with strong fields are ignored -> Z.
        clear_drivers();
        for (int i = 0; i < N; i++) set_drv(i, 0, i % 2, 50, 60);
        step("R2");
        // R1: level 1 uses the high strength.
        clear_drivers(); set_drv(0, 1, 1, 20, 5); step("R1");
        // R1: level 0 uses the low strength.
        clear_drivers(); set_drv(0, 1, 0, 20, 5); step("R1");
        // R9: one-cycle latency observed on the next compare of a change.
        clear_drivers(); set_drv(5, 1, 1, 33, 1); step("R9");
        // R1 / R4: active driver at level 1 with zero high strength is Z.
        clear_drivers(); set_drv(2, 1, 1, 0, 50); step("R4");
        // R3: weak pull-up overpowered by a strong 0.
        clear_drivers(); set_drv(0, 1, 1, 10, 0); set_drv(3, 1, 0, 0, 40); step("R3");
        // R5: close contenders disagree at margin 3.
        clear_drivers(); set_drv(1, 1, 1, 30, 0); set_drv(6, 1, 0, 0, 28); step("R5");
        // R7: the same pair at margin 2 lets the 1 win.
        mrg = 2; step("R7");
        // R7: margin 0, exact tie disagreeing -> X.
        clear_drivers(); mrg = 0; set_drv(0, 1, 1, 30, 0); set_drv(1, 1, 0, 0, 30); step("R7");
        // R7: margin 0, one step stronger wins.
        clear_drivers(); mrg = 0; set_drv(0, 1, 1, 31, 0); set_drv(1, 1, 0, 0, 30); step("R7");
        // R6: contenders agree on 1 despite a weaker 0.
        clear_drivers(); set_drv(0, 1, 1, 30, 0); set_drv(4, 1, 1, 29, 0);
        set_drv(7, 1, 0, 0, 10); step("R6");
        // R3: forcing 63 beats 60 by exactly the margin.
        clear_drivers(); set_drv(2, 1, 0, 0, 63); set_drv(3, 1, 1, 60, 0); step("R3");
        // R5: forcing 63 against 61 is X.
        clear_drivers(); set_drv(2, 1, 0, 0, 63); set_drv(3, 1, 1, 61, 0); step("R5");
        // R7: margin 63 makes strength 1 contend with 63.
        clear_drivers(); mrg = 63; set_drv(0, 1, 1, 63, 0); set_drv(7, 1, 0, 0, 1); step("R7");
        // R2: strong idle driver does not disturb a weak active one.
        clear_drivers(); set_drv(0, 1, 1, 5, 0); set_drv(1, 0, 0, 63, 63); step("R2");
        // R6: all eight agreeing on 0 at equal strength.
        clear_drivers(); for (int i = 0; i < N; i++) set_drv(i, 1, 0, 0, 17); step("R6");

        // Random vectors, tagged by the outcome the model predicts.
        for (int n = 0; n < 400; n++) begin
            clear_drivers();
            mrg = $urandom_range(0, 6);
            for (int i = 0; i < N; i++)
                set_drv(i, ($urandom_range(0, 3) != 0), $urandom_range(0, 1),
                        $urandom_range(0, 63), $urandom_range(0, 63));
            model(st, s);
            step(st == 2 ? "R4" : (st == 3 ? "R5" : "R3"));
        end
        @(negedge clk);
        compare_pending();

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule